// File: doc/BRIEF.md
# Two-Direction Traffic Phase Controller

This block runs the lamps of a four-way crossing as two groups. One group of green, yellow and red serves the north and south approaches together. A second group serves east and west. A sequencer steps through four phases: `PH_NS_GO`, `PH_NS_WARN`, `PH_EW_GO` and `PH_EW_WARN`. A dwell timer counts seconds and raises a short alarm and a long alarm. A purely combinational decoder turns the current phase into the six lamp outputs.

The timer advances only on clock cycles where the one-second tick input `sec_tick` is high. Because of this, a bench or a faster system can shorten real time simply by pulsing the tick more often. Each of the four transitions in the sequencer waits for its alarm:

- `GO_TO_WARN` on the north-south side waits for the long alarm.
- `WARN_TO_CROSS` waits for the short alarm.
- `CROSS_GO_TO_WARN` on the east-west side waits for the long alarm.
- `CROSS_WARN_TO_HOME` waits for the short alarm.

On each transition the sequencer restarts the timer in the same clock edge that updates the phase register. The dwell times are parameters, with defaults of 45 for green and 15 for yellow.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase becomes `PH_NS_GO` (NS green, EW red) and the dwell count becomes zero. As a result, a full green dwell is needed before the first transition.
- R2: The lamp outputs follow the phase, written as {ns_green,ns_yellow,ns_red,ew_green,ew_yellow,ew_red}: `PH_NS_GO`=100001, `PH_NS_WARN`=010001, `PH_EW_GO`=001100, `PH_EW_WARN`=001010. Exactly one lamp per direction is lit.
- R3: Phases advance only in the cyclic order `PH_NS_GO`, `PH_NS_WARN`, `PH_EW_GO`, `PH_EW_WARN`, then back to `PH_NS_GO`.
- R4: A green phase (`PH_NS_GO` or `PH_EW_GO`) holds until the dwell count has reached GREEN_SECS (45) counted ticks. It then leaves on the next rising edge.
- R5: A yellow phase (`PH_NS_WARN` or `PH_EW_WARN`) holds until YELLOW_SECS (15) ticks have been counted. It then leaves on the next rising edge.
- R6: The dwell count changes only on edges where `sec_tick` is high. With no ticks, the phase holds indefinitely.
- R7: Every phase change clears the dwell count on that same edge. A tick present on the transition edge is not counted toward the new phase.
- R8: North-south and east-west never both show green or yellow at the same time.
- R9: Once an alarm is raised, it stays high until the next restart, even if no further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-second count enable, sampled each clock |
| ns_green | output | 1 | North and south green lamp |
| ns_yellow | output | 1 | North and south yellow lamp |
| ns_red | output | 1 | North and south red lamp |
| ew_green | output | 1 | East and west green lamp |
| ew_yellow | output | 1 | East and west yellow lamp |
| ew_red | output | 1 | East and west red lamp |

## Verification
The properties assume that `rst` is high from time zero until after the first rising edge, and that `sec_tick` is a synchronous level sampled only at rising edges. The properties place no constraint on how ticks are spaced. The stimulus changes every input at falling edges. Most of the run uses one-cycle tick pulses separated by quiet cycles. A directed case holds the tick high on every cycle, so that a tick lands exactly on a transition edge, and another withholds ticks for a long stretch.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_NS_GO   = 2'b00,
        PH_NS_WARN = 2'b01,
        PH_EW_GO   = 2'b10,
        PH_EW_WARN = 2'b11
    } phase_t;

    typedef struct packed {
        logic green;
        logic yellow;
        logic red;
    } lamp_t;

    localparam lamp_t LAMP_GO   = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
    localparam lamp_t LAMP_WARN = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
    localparam lamp_t LAMP_STOP = '{green: 1'b0, yellow: 1'b0, red: 1'b1};

endpackage

// File: rtl/tlc_dwell_timer.sv
module tlc_dwell_timer #(
    parameter int SHORT_SECS = 15,
    parameter int LONG_SECS  = 45,
    parameter int CNT_W      = $clog2(LONG_SECS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             alarm_short,
    output logic             alarm_long
);

    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_SECS);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_SECS);

    // Saturating seconds counter; restart has priority over a tick.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (tick && (count != LONG_C)) begin
            count <= count + 1'b1;
        end
    end

    // Level alarms: held until the next restart.
    always_comb begin
        alarm_short = (count >= SHORT_C);
        alarm_long  = (count >= LONG_C);
    end

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alarm_short,
    input  logic   alarm_long,
    output phase_t phase,
    output logic   restart
);

    phase_t phase_next;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_NS_GO;
        end else begin
            phase <= phase_next;
        end
    end

    // Next-state logic
    always_comb begin
        phase_next = phase;
        unique case (phase)
            PH_NS_GO:   if (alarm_long)  phase_next = PH_NS_WARN;
            PH_NS_WARN: if (alarm_short) phase_next = PH_EW_GO;
            PH_EW_GO:   if (alarm_long)  phase_next = PH_EW_WARN;
            PH_EW_WARN: if (alarm_short) phase_next = PH_NS_GO;
            default:                     phase_next = PH_NS_GO;
        endcase
    end

    // Output logic: timer start on every transition
    always_comb begin
        restart = (phase_next != phase);
    end

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_t phase,
    output lamp_t  ns_lamp,
    output lamp_t  ew_lamp
);

    always_comb begin
        ns_lamp = LAMP_STOP;
        ew_lamp = LAMP_STOP;
        unique case (phase)
            PH_NS_GO:   ns_lamp = LAMP_GO;
            PH_NS_WARN: ns_lamp = LAMP_WARN;
            PH_EW_GO:   ew_lamp = LAMP_GO;
            PH_EW_WARN: ew_lamp = LAMP_WARN;
            default: begin
                ns_lamp = LAMP_STOP;
                ew_lamp = LAMP_STOP;
            end
        endcase
    end

endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl
    import tlc_pkg::*;
#(
    parameter int GREEN_SECS  = 45,
    parameter int YELLOW_SECS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    output logic ns_green,
    output logic ns_yellow,
    output logic ns_red,
    output logic ew_green,
    output logic ew_yellow,
    output logic ew_red
);

    localparam int CNT_W = $clog2(GREEN_SECS + 1);

    phase_t           phase_q;
    logic             timer_restart;
    logic             alarm_short;
    logic             alarm_long;
    logic [CNT_W-1:0] dwell_cnt;
    lamp_t            ns_lamp;
    lamp_t            ew_lamp;

    tlc_dwell_timer #(
        .SHORT_SECS (YELLOW_SECS),
        .LONG_SECS  (GREEN_SECS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (sec_tick),
        .restart     (timer_restart),
        .count       (dwell_cnt),
        .alarm_short (alarm_short),
        .alarm_long  (alarm_long)
    );

    tlc_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .alarm_short (alarm_short),
        .alarm_long  (alarm_long),
        .phase       (phase_q),
        .restart     (timer_restart)
    );

    tlc_lamp_decode u_dec (
        .phase   (phase_q),
        .ns_lamp (ns_lamp),
        .ew_lamp (ew_lamp)
    );

    assign ns_green  = ns_lamp.green;
    assign ns_yellow = ns_lamp.yellow;
    assign ns_red    = ns_lamp.red;
    assign ew_green  = ew_lamp.green;
    assign ew_yellow = ew_lamp.yellow;
    assign ew_red    = ew_lamp.red;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker
    import tlc_pkg::*;
#(
    parameter int GREEN_SECS  = 45,
    parameter int YELLOW_SECS = 15,
    parameter int CNT_W       = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input phase_t           phase,
    input logic [CNT_W-1:0] cnt,
    input logic             restart,
    input logic             alarm_long,
    input logic             alarm_short,
    input logic             ns_g,
    input logic             ns_y,
    input logic             ns_r,
    input logic             ew_g,
    input logic             ew_y,
    input logic             ew_r
);

    localparam logic [CNT_W-1:0] GREEN_C  = CNT_W'(GREEN_SECS);
    localparam logic [CNT_W-1:0] YELLOW_C = CNT_W'(YELLOW_SECS);

    a_r8_no_conflict: assert property (@(posedge clk) disable iff (rst)
        !((ns_g || ns_y) && (ew_g || ew_y)));

    a_r2_one_lamp_ns: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_g, ns_y, ns_r}) == 1);

    a_r2_one_lamp_ew: assert property (@(posedge clk) disable iff (rst)
        $countones({ew_g, ew_y, ew_r}) == 1);

    a_r3_cyclic_order: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase) |-> (phase == phase_t'($past(phase) + 2'd1)));

    a_r4_green_hold: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_NS_GO || phase == PH_EW_GO) && cnt < GREEN_C) |=> $stable(phase));

    a_r5_yellow_hold: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_NS_WARN || phase == PH_EW_WARN) && cnt < YELLOW_C) |=> $stable(phase));

    a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !restart) |=> $stable(cnt));

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    a_r9_long_alarm_held: assert property (@(posedge clk) disable iff (rst)
        (alarm_long && !restart) |=> alarm_long);

    a_r9_short_alarm_held: assert property (@(posedge clk) disable iff (rst)
        (alarm_short && !restart) |=> alarm_short);

endmodule

bind traffic_phase_ctrl tlc_checker #(
    .GREEN_SECS  (GREEN_SECS),
    .YELLOW_SECS (YELLOW_SECS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .phase       (phase_q),
    .cnt         (dwell_cnt),
    .restart     (timer_restart),
    .alarm_long  (alarm_long),
    .alarm_short (alarm_short),
    .ns_g        (ns_green),
    .ns_y        (ns_yellow),
    .ns_r        (ns_red),
    .ew_g        (ew_green),
    .ew_y        (ew_yellow),
    .ew_r        (ew_red)
);

// File: tb/traffic_phase_ctrl_test.sv
`timescale 1ns/100ps
module traffic_phase_ctrl_test;

    localparam real CLK_HALF = 2.5;
    localparam int  TICK_GAP = 4;
    localparam int  N_VEC    = 8;

    localparam logic [5:0] L_NS_GO   = 6'b100001;
    localparam logic [5:0] L_NS_WARN = 6'b010001;
    localparam logic [5:0] L_EW_GO   = 6'b001100;
    localparam logic [5:0] L_EW_WARN = 6'b001010;

    // ticks to apply, then expected lamps
    localparam int unsigned VEC_TICKS [N_VEC] = '{44, 1, 14, 1, 44, 1, 14, 1};
    localparam logic [5:0]  VEC_LAMPS [N_VEC] = '{L_NS_GO, L_NS_WARN, L_NS_WARN, L_EW_GO,
                                                  L_EW_GO, L_EW_WARN, L_EW_WARN, L_NS_GO};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_tick = 1'b0;
    logic ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_HALF) clk = ~clk;

    traffic_phase_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .ns_green  (ns_green),
        .ns_yellow (ns_yellow),
        .ns_red    (ns_red),
        .ew_green  (ew_green),
        .ew_yellow (ew_yellow),
        .ew_red    (ew_red)
    );

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: lamps got %b expected %b at %0t", req, got, exp, $time);
        end
        // R8 on every sample
        n_checks++;
        if ((got[5] || got[4]) && (got[2] || got[1])) begin
            n_fails++;
            $display("FAIL R8: conflicting lamps got %b expected no overlap", got);
        end
    endtask

    task automatic pulse_ticks(input int unsigned k);
        for (int unsigned i = 0; i < k; i++) begin
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            repeat (TICK_GAP - 1) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sec_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_fails++;
        $display("FAIL watchdog: run incomplete, got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset phase", L_NS_GO);

        // Vector table: two full cycles (R2 R3 R4 R5)
        for (int round = 0; round < 2; round++) begin
            for (int v = 0; v < N_VEC; v++) begin
                pulse_ticks(VEC_TICKS[v]);
                check((VEC_TICKS[v] == 1) ? "R3 R4 R5 transition" : "R2 R4 R5 dwell hold",
                      VEC_LAMPS[v]);
            end
        end

        // R6: no ticks, long wait, phase holds
        pulse_ticks(44);
        repeat (300) @(negedge clk);
        check("R6 hold without ticks", L_NS_GO);
        pulse_ticks(1);
        check("R6 R9 alarm held then leave", L_NS_WARN);

        // R1: mid-cycle reset returns home and clears the timer
        pulse_ticks(15);
        check("R3 to east-west green", L_EW_GO);
        pulse_ticks(20);
        do_reset();
        check("R1 reset mid-cycle", L_NS_GO);
        pulse_ticks(44);
        check("R1 timer cleared by reset", L_NS_GO);
        pulse_ticks(1);
        check("R1 R4 full dwell after reset", L_NS_WARN);

        // R7: tick held high every cycle
        do_reset();
        sec_tick = 1'b1;
        repeat (45) @(negedge clk);
        check("R4 green at 45 ticks", L_NS_GO);
        @(negedge clk);
        check("R4 leave after alarm", L_NS_WARN);
        repeat (15) @(negedge clk);
        check("R7 transition tick not counted", L_NS_WARN);
        @(negedge clk);
        check("R7 R5 yellow after restart", L_EW_GO);
        sec_tick = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule